// File: doc/BRIEF.md
# Configurable Macrocell Register

This block is the storage element of one programmable-logic macrocell. Static configuration bits choose its behaviour: a D, T, JK or SR flipflop, or a bypass setting in which the combinational input drives the output directly. The same configuration also chooses where the clock comes from. It can be one of the global clock inputs, taken true or inverted. It can be that global clock qualified by a product-term enable. Or it can be an array clock carried on a product-term signal.

Two product-term lines give an asynchronous preset and an asynchronous clear. A dedicated active-low global clear can also act on the register when the configuration allows it. The block drives the stored or bypassed value together with its complement. The configuration inputs are meant to stay static while the block runs. The bench changes them only while the affected clock is low.

Top module: `mcr_macrocell`

## Requirements
- R1: With `cfg_ff_mode` = 0 (D), an active clock edge loads `d_a` into the register.
- R2: With `cfg_ff_mode` = 1 (T), an active edge inverts the register when `d_a` = 1 and keeps it when `d_a` = 0.
- R3: With `cfg_ff_mode` = 2 (JK, `d_a` = J, `d_b` = K), an active edge acts as follows: J=0,K=0 holds; J=1,K=0 sets; J=0,K=1 clears; J=1,K=1 toggles.
- R4: With `cfg_ff_mode` = 3 (SR, `d_a` = S, `d_b` = R), an active edge acts as follows: S=1,R=0 sets; S=0,R=1 clears; S=0,R=0 holds; S=1,R=1 also holds.
- R5: Any `cfg_ff_mode` code with bit 2 set (4 is the nominal bypass code) makes `q` follow `d_a` combinationally. In that setting, clocks, `pt_pre`, `pt_clr` and the global clear have no effect on `q`.
- R6: In the global clock modes, `cfg_gclk_sel` picks `gclk[cfg_gclk_sel]`. The rising edge is active when `cfg_gclk_inv` = 0 and the falling edge is active when it is 1. A global clock that is not selected has no effect.
- R7: With `cfg_clk_mode` = 1 (global clock with enable), an active edge updates the register only when `pt_ena` = 1. When `pt_ena` = 0 the register holds.
- R8: With `cfg_clk_mode` = 2 or 3 (array clock), a rising edge of `pt_clk` clocks the register and the global clocks are ignored. `cfg_clk_mode` = 0 is the plain global clock.
- R9: `pt_pre` = 1 forces the register to 1 and `pt_clr` = 1 forces it to 0, both immediately and without a clock. When both are high, clear wins. When clear is released while preset is still held, the register goes to 1.
- R10: With `cfg_gclr_en` = 1, `gclr_n` = 0 clears the register to 0 at once. With `cfg_gclr_en` = 0, `gclr_n` has no effect.
- R11: `q_n` is always the complement of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | NUM_GCLK (2) | Global clock inputs |
| gclr_n | input | 1 | Dedicated global clear, active low |
| pt_clk | input | 1 | Product-term array clock |
| pt_ena | input | 1 | Product-term clock enable, active high |
| pt_pre | input | 1 | Product-term asynchronous preset, active high |
| pt_clr | input | 1 | Product-term asynchronous clear, active high |
| d_a | input | 1 | Data input: D, T, J, S, or the bypass source |
| d_b | input | 1 | Second data input: K or R |
| cfg_ff_mode | input | 3 | Register function: 0 D, 1 T, 2 JK, 3 SR, 4 to 7 bypass |
| cfg_clk_mode | input | 2 | Clock mode: 0 global, 1 global with enable, 2 or 3 array |
| cfg_gclk_sel | input | SEL_W (1) | Selects which global clock is used |
| cfg_gclr_en | input | 1 | Lets `gclr_n` clear this register |
| cfg_gclk_inv | input | 1 | Uses the inverted global clock |
| q | output | 1 | Register or bypass output |
| q_n | output | 1 | Complement of `q` |

## Verification
Preset and clear can be asserted in the same interval, so their priority is at stake. The bench raises `pt_clr` and then `pt_pre` between two clock edges and expects 0 while both are high. It then drops the clear alone and expects the register to jump to 1 before any clock edge arrives. A clock edge can also meet a low enable, or fall on a clock that is not selected or on the opposite polarity. The bench places data changes so that a wrong source or wrong edge would visibly load the new value, and it compares `q` a fraction of a cycle after each edge.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    // register function codes (bit 2 set = bypass)
    typedef enum logic [2:0] {
        FF_D      = 3'd0,
        FF_T      = 3'd1,
        FF_JK     = 3'd2,
        FF_SR     = 3'd3,
        FF_BYPASS = 3'd4
    } ff_mode_e;

    // clock mode codes (bit 1 set = array clock)
    typedef enum logic [1:0] {
        CK_GLOBAL    = 2'd0,
        CK_GLOBAL_EN = 2'd1,
        CK_ARRAY     = 2'd2
    } clk_mode_e;

    typedef struct packed {
        logic bit_v;
    } mcr_state_t;

    function automatic logic is_bypass(input logic [2:0] mode);
        return mode[2];
    endfunction

    function automatic logic is_array_clk(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/mcr_clk_sel.sv
module mcr_clk_sel #(
    parameter int NUM_GCLK = 2,
    localparam int SEL_W = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic [SEL_W-1:0]    sel,
    input  logic                inv,
    input  logic                use_array,
    input  logic                pt_clk,
    output logic                reg_clk
);

    logic global_raw;

    always_comb begin
        global_raw = gclk[sel];
        if (use_array) begin
            reg_clk = pt_clk;
        end else begin
            reg_clk = global_raw ^ inv;
        end
    end

endmodule

// File: rtl/mcr_next_state.sv
module mcr_next_state
    import mcr_pkg::*;
(
    input  logic [2:0] ff_mode,
    input  logic       hold,
    input  logic       cur,
    input  logic       in_a,
    input  logic       in_b,
    output logic       nxt
);

    logic func_val;

    always_comb begin
        func_val = cur;
        unique case (ff_mode)
            FF_D:    func_val = in_a;
            FF_T:    func_val = cur ^ in_a;
            FF_JK: begin
                unique case ({in_a, in_b})
                    2'b00:   func_val = cur;
                    2'b10:   func_val = 1'b1;
                    2'b01:   func_val = 1'b0;
                    default: func_val = ~cur;
                endcase
            end
            FF_SR: begin
                unique case ({in_a, in_b})
                    2'b10:   func_val = 1'b1;
                    2'b01:   func_val = 1'b0;
                    default: func_val = cur;
                endcase
            end
            default: func_val = cur;
        endcase
        nxt = hold ? cur : func_val;
    end

endmodule

// File: rtl/mcr_async_ctl.sv
module mcr_async_ctl (
    input  logic pt_pre,
    input  logic pt_clr,
    input  logic gclr_n,
    input  logic gclr_en,
    output logic clr_act,
    output logic pre_act
);

    always_comb begin
        clr_act = pt_clr | (gclr_en & ~gclr_n);
        // preset is masked by clear so releasing clear re-triggers preset
        pre_act = pt_pre & ~clr_act;
    end

endmodule

// File: rtl/mcr_macrocell.sv
module mcr_macrocell
    import mcr_pkg::*;
#(
    parameter int NUM_GCLK = 2,
    localparam int SEL_W = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                gclr_n,
    input  logic                pt_clk,
    input  logic                pt_ena,
    input  logic                pt_pre,
    input  logic                pt_clr,
    input  logic                d_a,
    input  logic                d_b,
    input  logic [2:0]          cfg_ff_mode,
    input  logic [1:0]          cfg_clk_mode,
    input  logic [SEL_W-1:0]    cfg_gclk_sel,
    input  logic                cfg_gclr_en,
    input  logic                cfg_gclk_inv,
    output logic                q,
    output logic                q_n
);

    mcr_state_t state_q;
    mcr_state_t state_d;

    logic reg_clk;
    logic clr_act;
    logic pre_act;
    logic hold_en;
    logic nxt_bit;
    logic bypass;

    assign bypass  = is_bypass(cfg_ff_mode);
    assign hold_en = (cfg_clk_mode == CK_GLOBAL_EN) & ~pt_ena;

    mcr_clk_sel #(.NUM_GCLK(NUM_GCLK)) u_clk_sel (
        .gclk      (gclk),
        .sel       (cfg_gclk_sel),
        .inv       (cfg_gclk_inv),
        .use_array (is_array_clk(cfg_clk_mode)),
        .pt_clk    (pt_clk),
        .reg_clk   (reg_clk)
    );

    mcr_next_state u_next (
        .ff_mode (cfg_ff_mode),
        .hold    (hold_en),
        .cur     (state_q.bit_v),
        .in_a    (d_a),
        .in_b    (d_b),
        .nxt     (nxt_bit)
    );

    mcr_async_ctl u_async (
        .pt_pre  (pt_pre),
        .pt_clr  (pt_clr),
        .gclr_n  (gclr_n),
        .gclr_en (cfg_gclr_en),
        .clr_act (clr_act),
        .pre_act (pre_act)
    );

    always_comb begin
        state_d       = state_q;
        state_d.bit_v = nxt_bit;
    end

    always_ff @(posedge reg_clk or posedge clr_act or posedge pre_act) begin
        if (clr_act) begin
            state_q <= '0;
        end else if (pre_act) begin
            state_q.bit_v <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        q   = bypass ? d_a : state_q.bit_v;
        q_n = ~q;
    end

endmodule

// File: rtl/mcr_checker.sv
module mcr_checker #(
    parameter int NUM_GCLK = 2,
    localparam int SEL_W = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
    input logic [NUM_GCLK-1:0] gclk,
    input logic                gclr_n,
    input logic                pt_pre,
    input logic                pt_clr,
    input logic                pt_ena,
    input logic                d_a,
    input logic [2:0]          cfg_ff_mode,
    input logic [1:0]          cfg_clk_mode,
    input logic [SEL_W-1:0]    cfg_gclk_sel,
    input logic                cfg_gclk_inv,
    input logic                q,
    input logic                q_n
);

    logic sclk;
    logic plain_cfg;
    logic en_cfg;
    logic async_any;

    assign sclk      = gclk[0];
    assign async_any = pt_pre | pt_clr;
    assign plain_cfg = (cfg_clk_mode == 2'd0) && (cfg_gclk_sel == '0) &&
                       !cfg_gclk_inv && (cfg_ff_mode == 3'd0);
    assign en_cfg    = (cfg_clk_mode == 2'd1) && (cfg_gclk_sel == '0) &&
                       !cfg_gclk_inv && !cfg_ff_mode[2];

    // R11
    complement_out_chk: assert property (@(posedge sclk) disable iff (!gclr_n)
        q_n == ~q);

    // R9
    clear_forces_zero_chk: assert property (@(posedge sclk) disable iff (!gclr_n)
        (pt_clr && !cfg_ff_mode[2]) |-> !q);

    // R9
    preset_forces_one_chk: assert property (@(posedge sclk) disable iff (!gclr_n)
        (pt_pre && !pt_clr && !cfg_ff_mode[2]) |-> q);

    // R5
    bypass_follows_chk: assert property (@(posedge sclk) disable iff (!gclr_n)
        cfg_ff_mode[2] |-> (q == d_a));

    // R1
    d_capture_chk: assert property (@(posedge sclk) disable iff (!gclr_n)
        (plain_cfg && !async_any) |=> (!plain_cfg || async_any || q == $past(d_a)));

    // R7
    enable_hold_chk: assert property (@(posedge sclk) disable iff (!gclr_n)
        (en_cfg && !pt_ena && !async_any) |=> (!en_cfg || async_any || $stable(q)));

endmodule

bind mcr_macrocell mcr_checker #(.NUM_GCLK(NUM_GCLK)) u_mcr_chk (
    .gclk         (gclk),
    .gclr_n       (gclr_n),
    .pt_pre       (pt_pre),
    .pt_clr       (pt_clr),
    .pt_ena       (pt_ena),
    .d_a          (d_a),
    .cfg_ff_mode  (cfg_ff_mode),
    .cfg_clk_mode (cfg_clk_mode),
    .cfg_gclk_sel (cfg_gclk_sel),
    .cfg_gclk_inv (cfg_gclk_inv),
    .q            (q),
    .q_n          (q_n)
);

// File: tb/mcr_macrocell_test.sv
`timescale 1ns/1ps
module mcr_macrocell_test;

    localparam real HALF = 2.0;                    // 250 MHz
    localparam int  WATCHDOG_NS = 200000 * 4;

    // vector: {mode[2:0], a, b, expected q after one rising gclk[0] edge}
    localparam int NVEC = 16;
    localparam logic [5:0] VEC [0:NVEC-1] = '{
        6'b000_10_1, 6'b000_00_0, 6'b000_11_1,
        6'b001_10_0, 6'b001_10_1, 6'b001_00_1,
        6'b010_00_1, 6'b010_01_0, 6'b010_10_1, 6'b010_11_0, 6'b010_11_1,
        6'b011_01_0, 6'b011_10_1, 6'b011_11_1, 6'b011_00_1, 6'b011_01_0
    };

    logic       gclk_a = 1'b0;
    logic       gclk_b = 1'b0;
    logic       gclr_n, pt_clk, pt_ena, pt_pre, pt_clr, d_a, d_b;
    logic [2:0] cfg_ff_mode;
    logic [1:0] cfg_clk_mode;
    logic [0:0] cfg_gclk_sel;
    logic       cfg_gclr_en, cfg_gclk_inv;
    logic       q, q_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(HALF) gclk_a = ~gclk_a;

    mcr_macrocell uut (
        .gclk         ({gclk_b, gclk_a}),
        .gclr_n       (gclr_n),
        .pt_clk       (pt_clk),
        .pt_ena       (pt_ena),
        .pt_pre       (pt_pre),
        .pt_clr       (pt_clr),
        .d_a          (d_a),
        .d_b          (d_b),
        .cfg_ff_mode  (cfg_ff_mode),
        .cfg_clk_mode (cfg_clk_mode),
        .cfg_gclk_sel (cfg_gclk_sel),
        .cfg_gclr_en  (cfg_gclr_en),
        .cfg_gclk_inv (cfg_gclk_inv),
        .q            (q),
        .q_n          (q_n)
    );

    // every check also covers R11 (q_n is the complement of q)
    task automatic chk(input string tag, input logic exp);
        checks++;
        if (q !== exp || q_n !== ~exp) begin
            errors++;
            $display("FAIL %s: q=%b q_n=%b, expected q=%b q_n=%b",
                     tag, q, q_n, exp, ~exp);
        end
    endtask

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0:    return "R1";
            3'd1:    return "R2";
            3'd2:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic low_phase();
        @(negedge gclk_a);
        #1;
    endtask

    task automatic after_rise();
        @(posedge gclk_a);
        #1;
    endtask

    initial begin
        #(WATCHDOG_NS);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run still active at %0d ns, expected finish earlier", WATCHDOG_NS);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        gclr_n = 1'b0; pt_clk = 1'b0; pt_ena = 1'b0; pt_pre = 1'b0; pt_clr = 1'b0;
        d_a = 1'b0; d_b = 1'b0;
        cfg_ff_mode = 3'd0; cfg_clk_mode = 2'd0; cfg_gclk_sel = 1'b0;
        cfg_gclr_en = 1'b1; cfg_gclk_inv = 1'b0;
        repeat (3) @(posedge gclk_a);
        #1;
        chk("R10 reset via global clear / R11", 1'b0);
        low_phase();
        gclr_n = 1'b1;

        // table walk: D, T, JK, SR on the plain rising global clock
        for (int i = 0; i < NVEC; i++) begin
            low_phase();
            cfg_ff_mode = VEC[i][5:3];
            d_a         = VEC[i][2];
            d_b         = VEC[i][1];
            after_rise();
            chk(mode_tag(VEC[i][5:3]), VEC[i][0]);
        end

        // R10: global clear ignored when disabled for this register
        low_phase();
        cfg_ff_mode = 3'd0; d_a = 1'b1; d_b = 1'b0;
        after_rise();
        chk("R1 load one", 1'b1);
        cfg_gclr_en = 1'b0; gclr_n = 1'b0;
        #0.3;
        chk("R10 gclr ignored when disabled", 1'b1);
        gclr_n = 1'b1;
        #0.2;
        cfg_gclr_en = 1'b1;

        // R9: clear, clear with preset, release of clear with preset held
        low_phase();
        pt_clr = 1'b1;
        #0.2 chk("R9 async clear", 1'b0);
        pt_pre = 1'b1;
        #0.2 chk("R9 clear wins over preset", 1'b0);
        pt_clr = 1'b0;
        #0.2 chk("R9 preset after clear release", 1'b1);
        pt_pre = 1'b0;
        #0.2 chk("R9 value held after release", 1'b1);

        // R5: bypass follows d_a; clear and clocks do not act on q
        low_phase();
        cfg_ff_mode = 3'd4; d_a = 1'b0;
        #0.2 chk("R5 bypass follows d_a low", 1'b0);
        d_a = 1'b1;
        #0.2 chk("R5 bypass follows d_a high", 1'b1);
        pt_clr = 1'b1;
        #0.2 chk("R5 clear has no effect in bypass", 1'b1);
        pt_clr = 1'b0;
        after_rise();
        chk("R5 clock has no effect in bypass", 1'b1);

        // R6: second global clock selected, first ignored
        low_phase();
        cfg_ff_mode = 3'd0; d_a = 1'b0;
        after_rise();
        chk("R1 load zero", 1'b0);
        low_phase();
        cfg_gclk_sel = 1'b1; d_a = 1'b1;
        after_rise();
        chk("R6 unselected clock ignored", 1'b0);
        gclk_b = 1'b1;
        #0.3 chk("R6 selected second clock loads", 1'b1);
        gclk_b = 1'b0;

        // R6: inverted global clock, falling edge active
        low_phase();
        cfg_gclk_sel = 1'b0; d_a = 1'b1;
        after_rise();
        cfg_gclk_inv = 1'b1; d_a = 1'b0;
        #0.2 chk("R6 no load on polarity change", 1'b1);
        low_phase();
        chk("R6 falling edge loads when inverted", 1'b0);
        d_a = 1'b1;
        after_rise();
        chk("R6 rising edge ignored when inverted", 1'b0);
        low_phase();
        chk("R6 next falling edge loads", 1'b1);
        cfg_gclk_inv = 1'b0;

        // R7: clock enable mode
        cfg_clk_mode = 2'd1; pt_ena = 1'b0; d_a = 1'b0;
        after_rise();
        chk("R7 hold with enable low", 1'b1);
        low_phase();
        pt_ena = 1'b1;
        after_rise();
        chk("R7 load with enable high", 1'b0);

        // R8: array clock
        low_phase();
        cfg_clk_mode = 2'd2; pt_ena = 1'b0; d_a = 1'b1;
        after_rise();
        chk("R8 global clock ignored in array mode", 1'b0);
        pt_clk = 1'b1;
        #0.3 chk("R8 array clock edge loads", 1'b1);
        pt_clk = 1'b0;
        low_phase();
        cfg_clk_mode = 2'd0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule